// File: doc/BRIEF.md
# Half-Word Masked GPIO Output Register

This block is the output side of a 32-pin general-purpose I/O controller. It keeps two 32-bit registers, one holding the level each pin should drive and one saying which pins are driven at all. Both registers drive the pad vectors straight from their flops. A simple request port reaches them: one valid strobe, a write flag, a word address and a write word.

Each register has three write addresses. A whole-word address replaces all 32 bits. Two half-word aliases each change only a chosen set of bits in one 16-bit half. The upper 16 bits of the written word form a per-bit enable mask. The lower 16 bits carry the new levels. Software can therefore set or clear any group of pins within a half in one bus write. It needs no read-modify-write, so two agents that touch different pins never undo each other's work.

Word address map: 0 value/whole, 1 value/low-half alias, 2 value/high-half alias, 3 enable/whole, 4 enable/low-half alias, 5 enable/high-half alias. Every other address is unmapped.

Top module: `hwm_gpio_out`

## Requirements
- R1: While rst_n is low at a rising clock edge, both registers are cleared to zero, so pad_out and pad_oe are all zero after that edge.
- R2: A write (req_valid=1, req_write=1) to address 0 loads the full 32-bit req_wdata into the value register, and it appears on pad_out after that edge.
- R3: A write to address 3 loads the full 32-bit req_wdata into the enable register, and it appears on pad_oe after that edge.
- R4: A write to a low-half alias (address 1 for value, 4 for enable) sets register bit i (0..15) to req_wdata[i] wherever req_wdata[16+i] is 1. Register bits 31:16 are unchanged.
- R5: A write to a high-half alias (address 2 for value, 5 for enable) sets register bit 16+i to req_wdata[i] wherever req_wdata[16+i] is 1. Register bits 15:0 are unchanged.
- R6: In an alias write, a register bit whose mask bit is 0 keeps its previous value. An all-zero mask leaves the register unchanged.
- R7: With req_valid=1 and req_write=0, rd_data in the same cycle returns the full register for addresses 0 and 3. For an alias, it returns the selected 16-bit half in bits 15:0 and zeros in bits 31:16.
- R8: A write to an unmapped address changes neither register. A read of an unmapped address returns zero, and rd_data is zero while req_valid is 0.
- R9: A request with req_write=0, or with req_valid=0, never changes either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write word (alias: mask in 31:16, levels in 15:0) |
| rd_data | output | 32 | Read data, combinational from the registers |
| pad_out | output | 32 | Pin output levels |
| pad_oe | output | 32 | Pin output enables |

## Verification
Register updates pass through one flop. A write presented in one cycle shows on pad_out or pad_oe one rising edge later, while read data is combinational and is due in the same cycle as its request. The bench drives each request just after a falling edge and compares rd_data and both pad vectors one time unit later. It then advances its behavioural model at the rising edge. Each compared value therefore reflects every edge before it and no later one, and a write and the read-back that follows it land on neighbouring cycles.

// File: rtl/hwm_gpio_pkg.sv
// Shared address map and access-target encoding for the half-word masked
// GPIO output register. Assumes a word-addressed request port.
package hwm_gpio_pkg;

    localparam int OFF_OUT_ALL = 0;
    localparam int OFF_OUT_LO  = 1;
    localparam int OFF_OUT_HI  = 2;
    localparam int OFF_OE_ALL  = 3;
    localparam int OFF_OE_LO   = 4;
    localparam int OFF_OE_HI   = 5;
    localparam int NUM_REGS    = 2;

    typedef enum logic [2:0] {
        TGT_NONE    = 3'd0,
        TGT_OUT_ALL = 3'd1,
        TGT_OUT_LO  = 3'd2,
        TGT_OUT_HI  = 3'd3,
        TGT_OE_ALL  = 3'd4,
        TGT_OE_LO   = 3'd5,
        TGT_OE_HI   = 3'd6
    } hwm_target_e;

endpackage

// File: rtl/hwm_addr_decode.sv
// Address decoder: maps a valid request address to one access target.
// Assumes addresses outside the map decode to TGT_NONE; no state is held.
module hwm_addr_decode
    import hwm_gpio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output hwm_target_e       tgt
);

    // Purpose: combinational address-to-target lookup.
    always_comb begin
        tgt = TGT_NONE;
        if (req_valid) begin
            if      (req_addr == ADDR_W'(OFF_OUT_ALL)) tgt = TGT_OUT_ALL;
            else if (req_addr == ADDR_W'(OFF_OUT_LO))  tgt = TGT_OUT_LO;
            else if (req_addr == ADDR_W'(OFF_OUT_HI))  tgt = TGT_OUT_HI;
            else if (req_addr == ADDR_W'(OFF_OE_ALL))  tgt = TGT_OE_ALL;
            else if (req_addr == ADDR_W'(OFF_OE_LO))   tgt = TGT_OE_LO;
            else if (req_addr == ADDR_W'(OFF_OE_HI))   tgt = TGT_OE_HI;
        end
    end

endmodule

// File: rtl/hwm_masked_reg.sv
// One W-bit register with a whole-word write and two half-word masked
// writes. In a masked write, wdata[W-1:W/2] is the bit mask and
// wdata[W/2-1:0] holds the levels. Assumes at most one strobe per cycle.
module hwm_masked_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_all,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    localparam int H = W / 2;

    logic [W-1:0] nxt;
    logic [H-1:0] mask;
    logic [H-1:0] vals;

    assign mask = wdata[W-1:H];
    assign vals = wdata[H-1:0];

    // One merge slice per half; the half index picks its strobe.
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic sel;
        assign sel = (h == 0) ? wr_lo : wr_hi;
        // Purpose: next value of this half for whole, masked or idle cycles.
        always_comb begin
            if (wr_all)
                nxt[h*H +: H] = wdata[h*H +: H];
            else if (sel)
                nxt[h*H +: H] = (q[h*H +: H] & ~mask) | (vals & mask);
            else
                nxt[h*H +: H] = q[h*H +: H];
        end
    end

    // Purpose: state flop with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> q == '0);

    // R2
    whole_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_all |=> q == $past(wdata));

    // R4
    lo_alias_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> q[W-1:H] == $past(q[W-1:H]));

    // R5
    hi_alias_lower_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> q[H-1:0] == $past(q[H-1:0]));

    // R6
    lo_mask_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> ((q[H-1:0] ^ $past(q[H-1:0])) & ~$past(wdata[W-1:H])) == '0);

    // R6
    hi_mask_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> ((q[W-1:H] ^ $past(q[W-1:H])) & ~$past(wdata[W-1:H])) == '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_all || wr_lo || wr_hi) |=> $stable(q));

endmodule

// File: rtl/hwm_read_mux.sv
// Read-data selector: whole registers for whole-word targets, the chosen
// half zero-extended for alias targets, zero when nothing is selected.
module hwm_read_mux
    import hwm_gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  hwm_target_e  tgt,
    input  logic [W-1:0] q_out,
    input  logic [W-1:0] q_oe,
    output logic [W-1:0] rd_data
);

    localparam int H = W / 2;

    // Purpose: combinational read-data select.
    always_comb begin
        rd_data = '0;
        unique case (tgt)
            TGT_OUT_ALL: rd_data = q_out;
            TGT_OUT_LO:  rd_data[H-1:0] = q_out[H-1:0];
            TGT_OUT_HI:  rd_data[H-1:0] = q_out[W-1:H];
            TGT_OE_ALL:  rd_data = q_oe;
            TGT_OE_LO:   rd_data[H-1:0] = q_oe[H-1:0];
            TGT_OE_HI:   rd_data[H-1:0] = q_oe[W-1:H];
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/hwm_gpio_out.sv
// Top of the half-word masked GPIO output register. It decodes the request,
// updates the value and enable registers and drives the pads from their flops.
// Assumes NUM_PINS is even, and that a read is requested with req_write low.
module hwm_gpio_out
    import hwm_gpio_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [NUM_PINS-1:0] req_wdata,
    output logic [NUM_PINS-1:0] rd_data,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    hwm_target_e tgt;
    logic [NUM_REGS-1:0][NUM_PINS-1:0] q;

    hwm_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .tgt       (tgt)
    );

    // Index 0 is the value register, index 1 the enable register.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        localparam hwm_target_e T_ALL = (r == 0) ? TGT_OUT_ALL : TGT_OE_ALL;
        localparam hwm_target_e T_LO  = (r == 0) ? TGT_OUT_LO  : TGT_OE_LO;
        localparam hwm_target_e T_HI  = (r == 0) ? TGT_OUT_HI  : TGT_OE_HI;
        hwm_masked_reg #(.W(NUM_PINS)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_all (req_write && tgt == T_ALL),
            .wr_lo  (req_write && tgt == T_LO),
            .wr_hi  (req_write && tgt == T_HI),
            .wdata  (req_wdata),
            .q      (q[r])
        );
    end

    hwm_read_mux #(.W(NUM_PINS)) u_rmux (
        .tgt     (tgt),
        .q_out   (q[0]),
        .q_oe    (q[1]),
        .rd_data (rd_data)
    );

    assign pad_out = q[0];
    assign pad_oe  = q[1];

    // R8
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_addr > ADDR_W'(OFF_OE_HI)) |-> rd_data == '0);

    // R8
    unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr > ADDR_W'(OFF_OE_HI))
        |=> ($stable(pad_out) && $stable(pad_oe)));

    // R3
    oe_whole_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_W'(OFF_OE_ALL))
        |=> pad_oe == $past(req_wdata));

endmodule

// File: tb/sim_hwm_gpio_out.sv
module sim_hwm_gpio_out;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data, pad_out, pad_oe;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // Behavioural reference state.
    logic [31:0] m_out = '0;
    logic [31:0] m_oe = '0;

    always #4 clk = ~clk;

    hwm_gpio_out u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic v, input logic [3:0] a);
        if (!v) return 32'h0;
        case (a)
            4'd0: return m_out;
            4'd1: return {16'h0, m_out[15:0]};
            4'd2: return {16'h0, m_out[31:16]};
            4'd3: return m_oe;
            4'd4: return {16'h0, m_oe[15:0]};
            4'd5: return {16'h0, m_oe[31:16]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] cur, input int base,
                                         input logic [31:0] d);
        logic [31:0] r = cur;
        for (int i = 0; i < 16; i++)
            if (d[16+i]) r[base+i] = d[i];
        return r;
    endfunction

    // Apply one request for one cycle; check in-cycle read and pads, then step the model.
    task automatic cyc(input logic v, input logic w, input logic [3:0] a,
                       input logic [31:0] d, input string tag, input bit chk = 1);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        #1;
        if (chk) begin
            cmp({tag, " rd_data"}, rd_data, m_read(v, a));
            cmp({tag, " pad_out"}, pad_out, m_out);
            cmp({tag, " pad_oe"}, pad_oe, m_oe);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_out = '0; m_oe = '0;
        end else if (v && w) begin
            case (a)
                4'd0: m_out = d;
                4'd1: m_out = merge(m_out, 0, d);
                4'd2: m_out = merge(m_out, 16, d);
                4'd3: m_oe = d;
                4'd4: m_oe = merge(m_oe, 0, d);
                4'd5: m_oe = merge(m_oe, 16, d);
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        cyc(0, 0, 0, 0, "R1 reset", 0);
        cyc(0, 0, 0, 0, "R1 reset");
        cyc(1, 1, 0, 32'hFFFF_FFFF, "R1 reset write blocked");
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, "R1 after reset");
        // R2 / R3 whole-word writes
        cyc(1, 1, 0, 32'hA5A5_3C3C, "R2 whole value");
        cyc(1, 0, 0, 0, "R7 read whole value");
        cyc(1, 1, 3, 32'h0F0F_F0F0, "R3 whole enable");
        cyc(1, 0, 3, 0, "R7 read whole enable");
        // R4 low alias
        cyc(1, 1, 1, 32'h00FF_1234, "R4 low alias value");
        cyc(1, 0, 1, 0, "R7 read low alias");
        cyc(1, 1, 4, 32'hFFFF_0001, "R4 low alias enable full mask");
        cyc(1, 0, 4, 0, "R7 read enable low alias");
        // R5 high alias
        cyc(1, 1, 2, 32'hF00F_ABCD, "R5 high alias value");
        cyc(1, 0, 2, 0, "R7 read high alias");
        cyc(1, 1, 5, 32'h8001_0000, "R5 high alias enable clear");
        cyc(1, 0, 5, 0, "R7 read enable high alias");
        // R6 zero mask and single bits
        cyc(1, 1, 1, 32'h0000_FFFF, "R6 zero mask low");
        cyc(1, 1, 2, 32'h0000_FFFF, "R6 zero mask high");
        cyc(1, 1, 2, 32'h8000_8000, "R6 single bit 31 set");
        cyc(1, 1, 1, 32'h0001_0000, "R6 single bit 0 clear");
        cyc(1, 0, 0, 0, "R6 readback");
        // R8 unmapped
        cyc(1, 1, 6, 32'hFFFF_FFFF, "R8 unmapped write 6");
        cyc(1, 1, 15, 32'hFFFF_FFFF, "R8 unmapped write 15");
        cyc(1, 0, 7, 0, "R8 unmapped read");
        cyc(0, 0, 0, 0, "R8 idle read zero");
        // R9 read or invalid requests change nothing
        cyc(1, 0, 0, 32'hDEAD_BEEF, "R9 read with data");
        cyc(0, 1, 0, 32'hDEAD_BEEF, "R9 invalid write");
        cyc(0, 1, 4, 32'hFFFF_FFFF, "R9 invalid alias write");
        cyc(1, 0, 3, 0, "R9 readback");
        // Back-to-back writes and a mixed pattern
        for (int k = 0; k < 24; k++) begin
            logic [31:0] d = 32'h9E37_79B9 * (k + 1);
            cyc(1, 1, 4'(k % 6), d, "R9 b2b write");
        end
        cyc(1, 0, 0, 0, "R2 final value");
        cyc(1, 0, 3, 0, "R3 final enable");
        // R1 reset mid-run
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, "R1 mid reset");
        rst_n = 1'b1;
        cyc(1, 0, 0, 0, "R1 cleared value");
        cyc(1, 0, 3, 0, "R1 cleared enable");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule